// File: doc/BRIEF.md
# Byte-Level I2C Transmit Master with Outcome Codes

This block masters a two-wire serial bus for transmit transfers. Each action is started by one command write. A command carries three control bits (start, stop, go) and a byte that is either a slave address with its direction bit or a data byte. The block carries out exactly one bus action. It then raises `done` and shows an 8-bit outcome code on `status`. While `done` is high and the block owns the bus, it holds SCL low. Nothing further happens on the bus until software writes the next command with go set.

The start and stop bits of each command select the next action:

- start=0, stop=0: send the loaded byte.
- start=1, stop=0: a START, or a repeated START if the block already owns the bus.
- start=0, stop=1: a STOP.
- start=1, stop=1: a STOP followed directly by a START.

Both lines are open-drain. The block only ever pulls a line low (`*_oe` high) and reads the line back through `*_in`. Bit timing is set by a quarter-bit divider. When the block releases SDA but reads it low during the SCL high phase of an address or data bit, it has lost arbitration. It lets go of both lines in the next cycle. A small bus monitor tracks START and STOP conditions so that a later START request can wait for a free bus.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, `status` is 0xF8, `done`, `rx_mode` and `stop_pend` are 0, and neither line is pulled low.
- R2: A START taken from a non-owned bus reports 0x08. A START issued while the bus is owned is a repeated START and reports 0x10.
- R3: A byte sent directly after a START or repeated START is an address. Its bits go out most significant first. When bit 0 is 0 (write), the outcome is 0x18 if the slave acknowledged and 0x20 if it did not.
- R4: Any other byte is data, with outcome 0x28 on ACK and 0x30 on NACK.
- R5: An address byte with bit 0 set (read) reports 0x40 and sets `rx_mode` when acknowledged. It reports 0x48 and leaves `rx_mode` clear when not acknowledged.
- R6: A stop-only command sets `stop_pend`. Once the STOP has been placed on the bus, `stop_pend` clears, both lines are released, `status` returns to 0xF8, and `done` stays 0.
- R7: A command with start and stop both set, issued while owning the bus, sends a STOP then a START and reports 0x08.
- R8: When the block releases SDA but reads it low while SCL is high during an address or data bit, it reports 0x38, raises `done` and releases both lines in the next cycle.
- R9: After arbitration loss, a go command with start=0 and stop=0 leaves both lines released, `status` at 0xF8 and `done` at 0.
- R10: After arbitration loss, a go command with start=1 waits while the bus is busy. It issues a START, reporting 0x08, only after a STOP has been seen on the bus.
- R11: `done` is cleared by an accepted go command. While `done` is high and the bus is owned, SCL is held low. A command write with go=0 leaves `done`, `status` and both lines unchanged.
- R12: The low three bits of `status` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_start | input | 1 | Start request bit |
| cmd_stop | input | 1 | Stop request bit |
| cmd_go | input | 1 | Go bit; a write without it is ignored |
| cmd_byte | input | BYTE_W | Address or data byte to send |
| bit_div | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| done | output | 1 | Action complete, waiting for the next command |
| status | output | 8 | Outcome code of the last action |
| rx_mode | output | 1 | Switched to receive after an acknowledged read address |
| stop_pend | output | 1 | STOP requested and not yet on the bus |

## Verification
The hardest situation to reach is the state after arbitration loss. The bus is then still held by another party, and no STOP has been seen. To get there, the bench's bus model pulls SDA low on the rising SCL edge of an address bit whose value is 1, then keeps SDA low. While SDA stays low, the bench issues the follow-up commands: a plain go, which must leave the bus alone, and a start request, which must stall. The bench then releases SDA while SCL floats high. That forms a STOP on the bus, and the stalled START must follow it.

// File: rtl/i2ctx_pkg.sv
package i2ctx_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAITFREE,
    SQ_START,
    SQ_BYTE,
    SQ_STOP
  } sq_state_t;

  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RSTART   = 8'h10;
  localparam logic [7:0] ST_AW_ACK   = 8'h18;
  localparam logic [7:0] ST_AW_NACK  = 8'h20;
  localparam logic [7:0] ST_D_ACK    = 8'h28;
  localparam logic [7:0] ST_D_NACK   = 8'h30;
  localparam logic [7:0] ST_ARB      = 8'h38;
  localparam logic [7:0] ST_AR_ACK   = 8'h40;
  localparam logic [7:0] ST_AR_NACK  = 8'h48;
  localparam logic [7:0] ST_NONE     = 8'hF8;

  // Outcome of a finished byte: address vs data, direction bit, ACK seen.
  function automatic logic [7:0] byte_status(input logic is_addr,
                                             input logic rd,
                                             input logic acked);
    if (!is_addr) return acked ? ST_D_ACK : ST_D_NACK;
    if (rd)       return acked ? ST_AR_ACK : ST_AR_NACK;
    return acked ? ST_AW_ACK : ST_AW_NACK;
  endfunction

  // A START issued while already owning the bus is a repeated START.
  function automatic logic [7:0] start_status(input logic owned);
    return owned ? ST_RSTART : ST_START;
  endfunction

endpackage

// File: rtl/i2ctx_tick.sv
module i2ctx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             qtick
);
  logic [DIV_W-1:0] cnt;

  assign qtick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || qtick) cnt <= '0;
    else                   cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/i2ctx_busmon.sv
module i2ctx_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_q, sda_q;
  logic start_seen, stop_seen;

  assign start_seen = scl_in && scl_q && sda_q && !sda_in;
  assign stop_seen  = scl_in && scl_q && !sda_q && sda_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_seen)     busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2ctx_seq.sv
module i2ctx_seq
  import i2ctx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qtick,
  input  logic              bus_busy,
  input  logic              sda_in,
  input  logic              cmd_wr,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_go,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              tick_en,
  output logic              scl_low,
  output logic              sda_low,
  output logic              done,
  output logic [7:0]        status,
  output logic              rx_mode,
  output logic              stop_pend,
  output logic              own,
  output logic              arb_evt,
  output logic              accept,
  output logic              stop_evt
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  sq_state_t         st;
  logic [1:0]        q;
  logic [CNT_W-1:0]  bitn;
  logic [BYTE_W-1:0] shreg;
  logic              is_addr, rd_addr, chain, ack_q;
  logic              last_bit;

  assign last_bit = (bitn == CNT_W'(BYTE_W));
  assign accept   = cmd_wr && cmd_go && (st == SQ_IDLE);
  assign tick_en  = (st == SQ_START) || (st == SQ_BYTE) || (st == SQ_STOP);
  assign arb_evt  = (st == SQ_BYTE) && qtick && (q == 2'd2) && !last_bit &&
                    shreg[BYTE_W-1] && !sda_in;
  assign stop_evt = (st == SQ_STOP) && qtick && (q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SQ_IDLE; q <= '0; bitn <= '0; shreg <= '0;
      is_addr <= 1'b0; rd_addr <= 1'b0; chain <= 1'b0; ack_q <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0; done <= 1'b0; status <= ST_NONE;
      rx_mode <= 1'b0; stop_pend <= 1'b0; own <= 1'b0;
    end else if (accept) begin
      done <= 1'b0;
      q    <= '0;
      unique case ({cmd_start, cmd_stop})
        2'b11: if (own) begin st <= SQ_STOP; stop_pend <= 1'b1; chain <= 1'b1; end
               else st <= SQ_WAITFREE;
        2'b10: st <= own ? SQ_START : SQ_WAITFREE;
        2'b01: if (own) begin st <= SQ_STOP; stop_pend <= 1'b1; chain <= 1'b0; end
        default: begin
          if (own && !rx_mode) begin
            st <= SQ_BYTE; shreg <= cmd_byte; bitn <= '0; rd_addr <= cmd_byte[0];
          end else if (!own) begin
            status <= ST_NONE; scl_low <= 1'b0; sda_low <= 1'b0;
          end
        end
      endcase
    end else if (st == SQ_WAITFREE) begin
      if (!bus_busy) begin st <= SQ_START; q <= '0; end
    end else if (qtick) begin
      q <= q + 2'd1;
      unique case (st)
        SQ_START: begin
          unique case (q)
            2'd0: begin sda_low <= 1'b0; scl_low <= own; end
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b1;
            default: begin
              scl_low <= 1'b1; status <= start_status(own); own <= 1'b1;
              is_addr <= 1'b1; done <= 1'b1; st <= SQ_IDLE;
            end
          endcase
        end
        SQ_BYTE: begin
          unique case (q)
            2'd0: begin scl_low <= 1'b1; sda_low <= last_bit ? 1'b0 : !shreg[BYTE_W-1]; end
            2'd1: scl_low <= 1'b0;
            2'd2: begin
              if (arb_evt) begin
                scl_low <= 1'b0; sda_low <= 1'b0; own <= 1'b0; status <= ST_ARB;
                done <= 1'b1; is_addr <= 1'b0; st <= SQ_IDLE;
              end else if (last_bit) ack_q <= !sda_in;
            end
            default: begin
              scl_low <= 1'b1;
              if (last_bit) begin
                status  <= byte_status(is_addr, rd_addr, ack_q);
                rx_mode <= is_addr && rd_addr && ack_q;
                done <= 1'b1; is_addr <= 1'b0; st <= SQ_IDLE;
              end else begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                bitn  <= bitn + CNT_W'(1);
              end
            end
          endcase
        end
        SQ_STOP: begin
          unique case (q)
            2'd0: begin sda_low <= 1'b1; scl_low <= 1'b1; end
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b0;
            default: begin
              own <= 1'b0; stop_pend <= 1'b0; rx_mode <= 1'b0; is_addr <= 1'b0;
              if (chain) st <= SQ_START;
              else begin st <= SQ_IDLE; status <= ST_NONE; end
            end
          endcase
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_go,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic [7:0]        status,
  output logic              rx_mode,
  output logic              stop_pend
);
  logic tick_en, qtick, bus_busy;
  logic bus_own, arb_evt, cmd_accept, stop_evt;

  i2ctx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .div(bit_div), .qtick(qtick)
  );

  i2ctx_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(bus_busy)
  );

  i2ctx_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .qtick(qtick), .bus_busy(bus_busy), .sda_in(sda_in),
    .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_go(cmd_go),
    .cmd_byte(cmd_byte), .tick_en(tick_en), .scl_low(scl_oe), .sda_low(sda_oe),
    .done(done), .status(status), .rx_mode(rx_mode), .stop_pend(stop_pend),
    .own(bus_own), .arb_evt(arb_evt), .accept(cmd_accept), .stop_evt(stop_evt)
  );
endmodule

// File: rtl/i2ctx_chk.sv
module i2ctx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_mode,
  input logic       stop_pend,
  input logic       own,
  input logic       arb_evt,
  input logic       accept,
  input logic       stop_evt
);
  p_arb_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_evt |=> (!scl_oe && !sda_oe && done && status == 8'h38));

  p_stop_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!stop_pend && !sda_oe && !scl_oe));

  p_go_clears_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done);

  p_scl_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && own) |-> scl_oe);

  p_rx_on_read_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_mode) |-> status == 8'h40);

  p_low_bits_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    status[2:0] == 3'b000);
endmodule

bind i2c_tx_master i2ctx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .done(done), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .rx_mode(rx_mode), .stop_pend(stop_pend), .own(bus_own),
  .arb_evt(arb_evt), .accept(cmd_accept), .stop_evt(stop_evt)
);

// File: tb/sim_i2c_tx_master.sv
`timescale 1ns/1ps
module sim_i2c_tx_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0, cmd_go = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] bit_div = 8'd3;
  logic slv_sda_low = 1'b0;
  logic scl_oe, sda_oe, done, rx_mode, stop_pend;
  logic [7:0] status;
  int n_chk = 0, n_fail = 0;

  wire scl = !scl_oe;
  wire sda = !(sda_oe || slv_sda_low);

  always #2.5 clk = ~clk;

  i2c_tx_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_go(cmd_go), .cmd_byte(cmd_byte), .bit_div(bit_div),
    .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done),
    .status(status), .rx_mode(rx_mode), .stop_pend(stop_pend)
  );

  // {start, stop, ack, exp_rx, byte[7:0], exp_status[7:0]}
  localparam logic [19:0] VEC [0:10] = '{
    {4'b1000, 8'h00, 8'h08},   // R2 START
    {4'b0010, 8'hA0, 8'h18},   // R3 addr write ACK
    {4'b0010, 8'h5A, 8'h28},   // R4 data ACK
    {4'b0000, 8'hC3, 8'h30},   // R4 data NACK
    {4'b1000, 8'h00, 8'h10},   // R2 repeated START
    {4'b0000, 8'h91, 8'h48},   // R5 read addr NACK
    {4'b1000, 8'h00, 8'h10},   // R2 repeated START
    {4'b0011, 8'h53, 8'h40},   // R5 read addr ACK
    {4'b1100, 8'h00, 8'h08},   // R7 STOP then START
    {4'b0000, 8'h42, 8'h20},   // R3 addr write NACK
    {4'b0100, 8'h00, 8'hF8}    // R6 STOP
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic s, input logic p, input logic g, input logic [7:0] b);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_start = s; cmd_stop = p; cmd_go = g; cmd_byte = b;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic slave_byte(input logic ack, input int arb_at, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl);
      cap = {cap[6:0], sda};
      if (i == arb_at) begin slv_sda_low = 1'b1; return; end
    end
    @(negedge scl); slv_sda_low = ack;
    @(posedge scl);
    @(negedge scl); slv_sda_low = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic string tag_of(input logic [19:0] v);
    if (v[19] && v[18]) return "R7";
    case (v[7:0])
      8'h08, 8'h10: return "R2";
      8'h18, 8'h20: return "R3";
      8'h28, 8'h30: return "R4";
      8'h40, 8'h48: return "R5";
      default:      return "R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    logic ok;
    logic [7:0] cap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'hF8);
    check("R1 done/rx/stop", {done, rx_mode, stop_pend}, 3'b000);
    check("R1 lines", {scl_oe, sda_oe}, 2'b00);

    for (int k = 0; k < 11; k++) begin
      logic [19:0] v;
      string t;
      v = VEC[k];
      t = tag_of(v);
      send_cmd(v[19], v[18], 1'b1, v[15:8]);
      if (v[18] && !v[19]) begin
        check("R6 stop_pend set", stop_pend, 1'b1);
        for (int i = 0; i < 3000 && stop_pend; i++) @(negedge clk);
        check("R6 stop_pend cleared", stop_pend, 1'b0);
        check("R6 status", status, 8'hF8);
        check("R6 done low, lines free", {done, scl_oe, sda_oe}, 3'b000);
      end else begin
        if (!v[19] && !v[18]) begin
          slave_byte(v[17], 99, cap);
          check({t, " byte on bus"}, cap, v[15:8]);
        end
        wait_done(ok);
        check({t, " done"}, ok, 1'b1);
        check({t, " status"}, status, v[7:0]);
        check({t, " rx_mode"}, rx_mode, v[16]);
        check("R12 low bits", status[2:0], 3'b000);
        check("R11 scl held", scl_oe, 1'b1);
      end
    end

    // R11: write without go is ignored
    send_cmd(1'b1, 1'b0, 1'b1, 8'h00);
    wait_done(ok);
    check("R2 start after stop", status, 8'h08);
    send_cmd(1'b0, 1'b1, 1'b0, 8'hFF);
    repeat (60) @(negedge clk);
    check("R11 go=0 done kept", done, 1'b1);
    check("R11 go=0 status kept", status, 8'h08);
    check("R11 go=0 lines kept", {scl_oe, stop_pend}, 2'b10);

    // R8: lose arbitration on bit 2 of 0xB0 (a 1)
    send_cmd(1'b0, 1'b0, 1'b1, 8'hB0);
    slave_byte(1'b0, 2, cap);
    wait_done(ok);
    check("R8 done", ok, 1'b1);
    check("R8 status", status, 8'h38);
    check("R8 lines released", {scl_oe, sda_oe}, 2'b00);

    // R10: START request waits until the bus shows a STOP
    send_cmd(1'b1, 1'b0, 1'b1, 8'h00);
    repeat (120) @(negedge clk);
    check("R10 stalled while busy", {done, scl_oe, sda_oe}, 3'b000);
    slv_sda_low = 1'b0;
    wait_done(ok);
    check("R10 start after free", {ok, status}, {1'b1, 8'h08});

    // R9: after another loss, a plain go leaves the bus alone
    send_cmd(1'b0, 1'b0, 1'b1, 8'hB0);
    slave_byte(1'b0, 0, cap);
    wait_done(ok);
    check("R8 status second loss", status, 8'h38);
    send_cmd(1'b0, 1'b0, 1'b1, 8'h55);
    repeat (120) @(negedge clk);
    check("R9 status", status, 8'hF8);
    check("R9 done and lines", {done, scl_oe, sda_oe}, 3'b000);
    slv_sda_low = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule